// File: doc/BRIEF.md
# CAN Message Time Stamp Unit

This block keeps a free-running 16-bit timer that advances once per bit-time tick, and takes a copy of it whenever the protocol engine reports that a frame has reached its identifier field. That copy is held as a pending stamp. It is only handed to the message buffer store path later, once the frame's fate is known. A received frame commits the stamp when it is stored into a receive buffer, and the write carries that buffer's index. A transmitted frame commits it only when the transmission succeeds. An abort, such as lost arbitration or a bus error, throws the pending stamp away and no write is made.

For network time synchronisation, the timer can be cleared by a reception that is stored into buffer 0. This happens only while the sync enable input is high. The clear lands on the same clock edge as the stamp write. The stamp written for that frame is the value captured before the clear.

Top module: `ts_stamp_unit`

## Requirements
- R1: After reset, `timer_o`, `stamp_o` and `rx_idx_o` are all zero, and both write strobes are low.
- R2: `timer_o` goes up by one on each clock edge where `tick_i` is high, wraps from 0xFFFF to 0x0000, and holds its value when `tick_i` is low.
- R3: A high `id_start_i` captures the value `timer_o` shows in that same cycle and marks a stamp as pending. A new capture replaces any older pending stamp.
- R4: `rx_store_i` with a pending stamp, and no abort in the same cycle, makes `rx_we_o` high for the next cycle. In that cycle `stamp_o` holds the captured value and `rx_idx_o` holds the `rx_idx_i` from the strobe cycle.
- R5: `tx_done_i` with a pending stamp, and no abort or receive store in the same cycle, makes `tx_we_o` high for the next cycle, with `stamp_o` holding the captured value.
- R6: `abort_i` clears the pending stamp. A store or done strobe in the same cycle as the abort, or any one after it, causes no write.
- R7: A store or done strobe with no pending stamp causes no write. A committed stamp stops being pending, so a second strobe for the same capture causes no write.
- R8: When `sync_en_i` is high and a receive store to index 0 commits, `timer_o` reads 0x0000 on the next cycle, whether or not `tick_i` is high. The stamp written is the value captured before the clear.
- R9: A committed receive store to any other index, or to index 0 while `sync_en_i` is low, leaves the timer's counting unchanged.
- R10: If `rx_store_i` and `tx_done_i` are both high with a pending stamp, only the receive write is made.
- R11: `stamp_o` and `rx_idx_o` change only in cycles where a write strobe is high, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One pulse per bit time |
| id_start_i | input | 1 | The frame on the bus has reached its identifier field |
| rx_store_i | input | 1 | The received frame is being stored into a buffer |
| rx_idx_i | input | 4 | Index of the receive buffer being written |
| tx_done_i | input | 1 | The transmission finished successfully |
| abort_i | input | 1 | The frame was abandoned (lost arbitration or error) |
| sync_en_i | input | 1 | Allows a store into buffer 0 to clear the timer |
| timer_o | output | 16 | Running timer value |
| stamp_o | output | 16 | Stamp value for the write in progress |
| rx_we_o | output | 1 | Stamp write strobe for a receive buffer |
| rx_idx_o | output | 4 | Receive buffer index for the stamp write |
| tx_we_o | output | 1 | Stamp write strobe for the transmit buffer |

## Verification
The directed patterns each target one effect. Long stretches of ticks test counting and the wrap, and cycles without ticks test that the timer holds. A capture followed by a receive store, and separately by a transmit success, shows that the stamp comes from the identifier cycle and not the commit cycle. An abort, a repeated strobe and a strobe with no capture each show that nothing is pending. Stores to buffer 0 with sync on and off, and to another buffer, tell the timer clear apart from plain counting. This includes a store that coincides with a tick, which shows the clear taking priority. Simultaneous receive and transmit strobes show which one wins. The random phase mixes all strobes densely with a small index range, so that sync clears, re-captures and aborts overlap in ways the directed cases do not reach.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int unsigned TS_W  = 16;
  localparam int unsigned IDX_W = 4;

  typedef enum logic [1:0] {
    CMT_NONE = 2'd0,
    CMT_RX   = 2'd1,
    CMT_TX   = 2'd2
  } commit_e;

  function automatic logic [TS_W-1:0] ts_advance(input logic [TS_W-1:0] cur,
                                                 input logic tick,
                                                 input logic clear);
    logic [TS_W-1:0] nxt;
    if (clear)     nxt = '0;
    else if (tick) nxt = cur + 1'b1;
    else           nxt = cur;
    return nxt;
  endfunction

  function automatic commit_e ts_pick(input logic pend, input logic rx,
                                      input logic tx, input logic abort);
    commit_e c;
    if (!pend || abort) c = CMT_NONE;
    else if (rx)        c = CMT_RX;
    else if (tx)        c = CMT_TX;
    else                c = CMT_NONE;
    return c;
  endfunction
endpackage

// File: rtl/ts_timer.sv
module ts_timer
  import ts_pkg::*;
#(
  parameter int unsigned W = TS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         clear_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else if (clear_i) count_q <= '0;
    else if (tick_i)  count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
endmodule

// File: rtl/ts_capture.sv
module ts_capture
  import ts_pkg::*;
#(
  parameter int unsigned W = TS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         id_start_i,
  input  logic         rx_store_i,
  input  logic         tx_done_i,
  input  logic         abort_i,
  input  logic [W-1:0] timer_i,
  output logic         pending_o,
  output logic [W-1:0] held_o,
  output commit_e      commit_o
);
  logic         pend_q;
  logic [W-1:0] held_q;
  commit_e      commit_w;

  assign commit_w = ts_pick(pend_q, rx_store_i, tx_done_i, abort_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      held_q <= '0;
    end else if (id_start_i) begin
      pend_q <= 1'b1;
      held_q <= timer_i;
    end else if (abort_i || (commit_w != CMT_NONE)) begin
      pend_q <= 1'b0;
    end
  end

  assign pending_o = pend_q;
  assign held_o    = held_q;
  assign commit_o  = commit_w;
endmodule

// File: rtl/ts_writer.sv
module ts_writer
  import ts_pkg::*;
#(
  parameter int unsigned W  = TS_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  commit_e       commit_i,
  input  logic [W-1:0]  held_i,
  input  logic [IW-1:0] idx_i,
  output logic [W-1:0]  stamp_o,
  output logic [IW-1:0] idx_o,
  output logic          rx_we_o,
  output logic          tx_we_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp_o <= '0;
      idx_o   <= '0;
      rx_we_o <= 1'b0;
      tx_we_o <= 1'b0;
    end else begin
      rx_we_o <= (commit_i == CMT_RX);
      tx_we_o <= (commit_i == CMT_TX);
      if (commit_i != CMT_NONE) stamp_o <= held_i;
      if (commit_i == CMT_RX)   idx_o   <= idx_i;
    end
  end
endmodule

// File: rtl/ts_stamp_unit.sv
module ts_stamp_unit
  import ts_pkg::*;
#(
  parameter int unsigned W  = TS_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          id_start_i,
  input  logic          rx_store_i,
  input  logic [IW-1:0] rx_idx_i,
  input  logic          tx_done_i,
  input  logic          abort_i,
  input  logic          sync_en_i,
  output logic [W-1:0]  timer_o,
  output logic [W-1:0]  stamp_o,
  output logic          rx_we_o,
  output logic [IW-1:0] rx_idx_o,
  output logic          tx_we_o
);
  logic         pending_w;
  logic [W-1:0] held_w;
  commit_e      commit_w;
  logic         sync_clr_w;

  // Named event: a committed store to buffer 0 with sync on clears the timer.
  assign sync_clr_w = (commit_w == CMT_RX) && sync_en_i && (rx_idx_i == '0);

  ts_timer #(.W(W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .clear_i(sync_clr_w), .count_o(timer_o)
  );

  ts_capture #(.W(W)) u_capture (
    .clk(clk), .rst_n(rst_n), .id_start_i(id_start_i), .rx_store_i(rx_store_i),
    .tx_done_i(tx_done_i), .abort_i(abort_i), .timer_i(timer_o),
    .pending_o(pending_w), .held_o(held_w), .commit_o(commit_w)
  );

  ts_writer #(.W(W), .IW(IW)) u_writer (
    .clk(clk), .rst_n(rst_n), .commit_i(commit_w), .held_i(held_w), .idx_i(rx_idx_i),
    .stamp_o(stamp_o), .idx_o(rx_idx_o), .rx_we_o(rx_we_o), .tx_we_o(tx_we_o)
  );
endmodule

// File: rtl/ts_stamp_unit_chk.sv
module ts_stamp_unit_chk
  import ts_pkg::*;
#(
  parameter int unsigned W  = TS_W,
  parameter int unsigned IW = IDX_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          rx_store_i,
  input logic          sync_en_i,
  input logic [IW-1:0] rx_idx_i,
  input logic [W-1:0]  timer_o,
  input logic [W-1:0]  stamp_o,
  input logic [IW-1:0] rx_idx_o,
  input logic          rx_we_o,
  input logic          tx_we_o,
  input logic          pending_w,
  input logic          sync_clr_w
);
  AST_TICK_INC: assert property (@(posedge clk) disable iff (!rst_n) (tick_i && !sync_clr_w) |=> timer_o == $past(timer_o) + 1'b1); // R2
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!tick_i && !sync_clr_w) |=> $stable(timer_o)); // R2
  AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n) sync_clr_w |=> timer_o == '0); // R8
  AST_SYNC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) sync_clr_w |-> (rx_store_i && sync_en_i && rx_idx_i == '0)); // R9
  AST_NO_PEND_NO_WR: assert property (@(posedge clk) disable iff (!rst_n) !pending_w |=> (!rx_we_o && !tx_we_o)); // R7
  AST_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rx_we_o && tx_we_o)); // R11
  AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!rx_we_o && !tx_we_o) |-> ($stable(stamp_o) || $rose(rst_n))); // R11
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!rx_we_o) |-> ($stable(rx_idx_o) || $rose(rst_n))); // R11
endmodule

bind ts_stamp_unit ts_stamp_unit_chk #(.W(W), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_store_i(rx_store_i),
  .sync_en_i(sync_en_i), .rx_idx_i(rx_idx_i), .timer_o(timer_o), .stamp_o(stamp_o),
  .rx_idx_o(rx_idx_o), .rx_we_o(rx_we_o), .tx_we_o(tx_we_o),
  .pending_w(pending_w), .sync_clr_w(sync_clr_w)
);

// File: tb/test_ts_stamp_unit.sv
module test_ts_stamp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, id_start_i = 1'b0, rx_store_i = 1'b0;
  logic [3:0]  rx_idx_i = '0;
  logic        tx_done_i = 1'b0, abort_i = 1'b0, sync_en_i = 1'b0;
  logic [15:0] timer_o, stamp_o;
  logic        rx_we_o, tx_we_o;
  logic [3:0]  rx_idx_o;

  int unsigned n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  // reference state
  logic [15:0] m_timer = '0, m_cap = '0, m_stamp = '0;
  logic        m_pend = 1'b0, m_rxwe = 1'b0, m_txwe = 1'b0;
  logic [3:0]  m_idx = '0;

  always #5 clk = ~clk;

  ts_stamp_unit i_ts_stamp_unit (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .id_start_i(id_start_i),
    .rx_store_i(rx_store_i), .rx_idx_i(rx_idx_i), .tx_done_i(tx_done_i),
    .abort_i(abort_i), .sync_en_i(sync_en_i), .timer_o(timer_o), .stamp_o(stamp_o),
    .rx_we_o(rx_we_o), .rx_idx_o(rx_idx_o), .tx_we_o(tx_we_o)
  );

  function automatic logic [15:0] bump(input logic [15:0] v);
    return (v == 16'hFFFF) ? 16'h0000 : v + 16'd1;
  endfunction

  task automatic cmp(input string req, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic compare_all(input string req);
    cmp(req, "timer", timer_o, m_timer);
    cmp(req, "stamp", stamp_o, m_stamp);
    cmp(req, "rx_we", rx_we_o, m_rxwe);
    cmp(req, "tx_we", tx_we_o, m_txwe);
    cmp(req, "rx_idx", rx_idx_o, m_idx);
  endtask

  // One clock: drive at negedge, update reference at posedge, compare at next negedge.
  task automatic cyc(input string req, input logic tk, input logic ids, input logic rx,
                     input logic [3:0] idx, input logic tx, input logic ab, input logic se);
    logic rx_ok, tx_ok, clr;
    tick_i = tk; id_start_i = ids; rx_store_i = rx; rx_idx_i = idx;
    tx_done_i = tx; abort_i = ab; sync_en_i = se;
    @(posedge clk);
    rx_ok = m_pend && !ab && rx;
    tx_ok = m_pend && !ab && !rx && tx;
    clr   = rx_ok && se && (idx == 4'd0);
    m_rxwe = rx_ok;
    m_txwe = tx_ok;
    if (rx_ok || tx_ok) m_stamp = m_cap;
    if (rx_ok) m_idx = idx;
    if (ids) begin
      m_pend = 1'b1;
      m_cap  = m_timer;
    end else if (ab || rx_ok || tx_ok) begin
      m_pend = 1'b0;
    end
    if (clr) m_timer = '0;
    else if (tk) m_timer = bump(m_timer);
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic idle(input string req, input int n, input logic tk);
    for (int i = 0; i < n; i++) cyc(req, tk, 0, 0, 4'd0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] snap;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R2: counting and holding
    idle("R2", 10, 1'b1);
    idle("R2", 4, 1'b0);

    // R3/R4: capture then store into buffer 5 several ticks later
    snap = m_timer;
    cyc("R3", 1, 1, 0, 4'd0, 0, 0, 0);
    idle("R3", 5, 1'b1);
    cyc("R4", 1, 0, 1, 4'd5, 0, 0, 1);
    cmp("R4", "stamp_from_id_cycle", stamp_o, snap);
    cmp("R4", "idx", rx_idx_o, 4'd5);

    // R5: transmit success
    snap = m_timer;
    cyc("R5", 1, 1, 0, 4'd0, 0, 0, 0);
    idle("R5", 3, 1'b1);
    cyc("R5", 0, 0, 0, 4'd0, 1, 0, 0);
    cmp("R5", "tx_we", tx_we_o, 1);
    cmp("R5", "stamp", stamp_o, snap);

    // R7: second done after commit, and done with nothing pending
    cyc("R7", 0, 0, 0, 4'd0, 1, 0, 0);
    cmp("R7", "tx_we_repeat", tx_we_o, 0);
    cyc("R7", 0, 0, 1, 4'd3, 0, 0, 0);
    cmp("R7", "rx_we_nopend", rx_we_o, 0);

    // R6: abort then strobe; abort in same cycle as strobe
    cyc("R6", 1, 1, 0, 4'd0, 0, 0, 0);
    cyc("R6", 1, 0, 0, 4'd0, 0, 1, 0);
    cyc("R6", 1, 0, 1, 4'd2, 0, 0, 0);
    cmp("R6", "rx_we_after_abort", rx_we_o, 0);
    cyc("R6", 1, 1, 0, 4'd0, 0, 0, 0);
    cyc("R6", 1, 0, 0, 4'd0, 1, 1, 0);
    cmp("R6", "tx_we_with_abort", tx_we_o, 0);

    // R8: sync clear on buffer 0 with a coincident tick
    idle("R8", 7, 1'b1);
    snap = m_timer;
    cyc("R8", 1, 1, 0, 4'd0, 0, 0, 0);
    idle("R8", 2, 1'b1);
    cyc("R8", 1, 0, 1, 4'd0, 0, 0, 1);
    cmp("R8", "timer_cleared", timer_o, 0);
    cmp("R8", "stamp_pre_clear", stamp_o, snap);

    // R9: buffer 0 with sync off, and another buffer with sync on
    idle("R9", 6, 1'b1);
    cyc("R9", 1, 1, 0, 4'd0, 0, 0, 0);
    snap = m_timer;
    cyc("R9", 1, 0, 1, 4'd0, 0, 0, 0);
    cmp("R9", "timer_kept", timer_o, bump(snap));
    cyc("R9", 1, 1, 0, 4'd0, 0, 0, 1);
    snap = m_timer;
    cyc("R9", 1, 0, 1, 4'd9, 0, 0, 1);
    cmp("R9", "timer_kept_idx9", timer_o, bump(snap));

    // R10: receive and transmit together
    cyc("R10", 0, 1, 0, 4'd0, 0, 0, 0);
    cyc("R10", 0, 0, 1, 4'd6, 1, 0, 0);
    cmp("R10", "rx_we", rx_we_o, 1);
    cmp("R10", "tx_we", tx_we_o, 0);

    // R3: re-capture replaces older stamp
    cyc("R3", 1, 1, 0, 4'd0, 0, 0, 0);
    idle("R3", 4, 1'b1);
    snap = m_timer;
    cyc("R3", 1, 1, 0, 4'd0, 0, 0, 0);
    cyc("R3", 1, 0, 0, 4'd0, 1, 0, 0);
    cmp("R3", "newest_capture", stamp_o, snap);

    // R2: wrap from 0xFFFF
    while (m_timer != 16'hFFFF) cyc("R2", 1, 0, 0, 4'd0, 0, 0, 0);
    cyc("R2", 1, 0, 0, 4'd0, 0, 0, 0);
    cmp("R2", "wrap", timer_o, 16'h0000);

    // Random mix (R4 R5 R6 R8 R11)
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      cyc("R11", ($urandom % 2) == 0, ($urandom % 8) == 0, ($urandom % 6) == 0,
          4'($urandom % 3), ($urandom % 6) == 0, ($urandom % 16) == 0, ($urandom % 2) == 0);
      n_cmp++;
      if (rx_we_o && tx_we_o) begin
        n_bad++;
        $display("FAIL R11 strobes: actual=both expected=at_most_one");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule